// File: doc/BRIEF.md
# Static-Region Multi-Queue Pointer Manager

This block keeps the read and write positions of many FIFO queues that share one external frame buffer. The buffer is cut into equal, power-of-two regions, one per queue. Each queue has a single descriptor word in an on-chip RAM. The word holds the queue's head pointer (next frame to read), its tail pointer (next frame to write) and a copy of its status flags. Each pointer is a fixed queue-number field followed by a frame counter that wraps inside the region.

A scheduler issues at most one enqueue or dequeue request per cycle, tagged with a queue number. The block reads that queue's descriptor. One cycle later it presents the chosen external byte address to the memory controller port, reports the queue's updated flags, and writes the advanced descriptor back. Enqueues to a full queue are refused with an error pulse. Dequeues from an empty queue issue nothing. A write that fills a queue raises a service request that names the queue.

After reset, the controller is in state `QM_LOAD`. A counter writes each queue's region base into its descriptor. On the last queue it takes the transition `load_done` into state `QM_SERVE`, and it stays there until the next reset. `ready` is high only in `QM_SERVE`. If two requests in a row target the same queue, the second one uses the descriptor being written back rather than the stale RAM word.

Top module: `qm_queue_mgr`

## Requirements
- R1: After reset, `ready` stays low for exactly NUM_Q cycles while descriptors load, then stays high. A request presented while `ready` is low is ignored: it produces no response, and the queue still reads as empty afterwards.
- R2: An accepted enqueue produces, in the next cycle, `mem_valid`=1, `mem_write`=1 and `mem_addr` = queue×2^13 + tail_index×64, where tail_index (7 bits) is the queue's frame count modulo 128 (default parameters).
- R3: An accepted dequeue of a non-empty queue produces, in the next cycle, `mem_valid`=1, `mem_write`=0 and `mem_addr` = queue×2^13 + head_index×64.
- R4: Each serviced access advances its pointer by one frame. Index 127 is followed by index 0 of the same region.
- R5: A dequeue of an empty queue gives `mem_valid`=0 and changes no pointer.
- R6: An enqueue to a full queue (occupancy 128) gives `rsp_err`=1 and `mem_valid`=0 and changes no pointer.
- R7: `rsp_empty` is 1 when the post-access occupancy (tail minus head) is 0. `rsp_full` is 1 when it equals 128.
- R8: `rsp_afull` is 1 when the post-access occupancy is at least `afull_level`. `rsp_aempty` is 1 when it is at most `aempty_level`.
- R9: `svc_req` pulses with `svc_qid` = queue in the response cycle of the enqueue that makes the queue full, and at no other time.
- R10: Back-to-back requests to the same queue see each other's updates.
- R11: Queues are independent: an access to one queue never moves another queue's pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | output | 1 | Descriptors loaded; requests accepted |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = enqueue, 0 = dequeue |
| req_qid | input | QID_W | Target queue |
| afull_level | input | CNT_W | Almost-full occupancy threshold |
| aempty_level | input | CNT_W | Almost-empty occupancy threshold |
| mem_valid | output | 1 | External access issued |
| mem_write | output | 1 | 1 = frame write, 0 = frame read |
| mem_addr | output | ADDR_W | External byte address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_qid | output | QID_W | Queue of the response |
| rsp_err | output | 1 | Enqueue refused (queue full) |
| rsp_empty | output | 1 | Post-access empty flag |
| rsp_full | output | 1 | Post-access full flag |
| rsp_afull | output | 1 | Post-access almost-full flag |
| rsp_aempty | output | 1 | Post-access almost-empty flag |
| svc_req | output | 1 | Queue just became full |
| svc_qid | output | QID_W | Queue needing service |

## Verification
Every response port is due exactly one clock edge after the edge that samples a request. The bench drives a request on a falling edge and reads its response on the next falling edge, in the same step that drives the following request, so back-to-back traffic is checked with no gaps. `ready` is due after NUM_Q edges from reset release, and the bench counts falling edges until it rises. Pointer effects of refused or idle requests are observed through the address of the next serviced access to that queue.

// File: rtl/qm_pkg.sv
package qm_pkg;
    typedef enum logic {
        QM_LOAD  = 1'b0,
        QM_SERVE = 1'b1
    } qm_state_e;
endpackage

// File: rtl/qm_desc_ram.sv
module qm_desc_ram #(
    parameter int WORDS = 64,
    parameter int W     = 20,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);
    logic [W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (rd_en) rdata <= mem[raddr];
    end
endmodule

// File: rtl/qm_occ_flags.sv
module qm_occ_flags #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] head_cnt,
    input  logic [CNT_W-1:0] tail_cnt,
    input  logic [CNT_W-1:0] afull_level,
    input  logic [CNT_W-1:0] aempty_level,
    output logic [CNT_W-1:0] occ,
    output logic             empty,
    output logic             full,
    output logic             afull,
    output logic             aempty
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(1) << (CNT_W - 1);

    always_comb begin
        occ    = tail_cnt - head_cnt;
        empty  = (occ == '0);
        full   = (occ == CAP);
        afull  = (occ >= afull_level);
        aempty = (occ <= aempty_level);
    end
endmodule

// File: rtl/qm_queue_mgr.sv
module qm_queue_mgr #(
    parameter int NUM_Q      = 64,
    parameter int FRAME_LOG2 = 6,
    parameter int DEPTH_LOG2 = 7,
    parameter int ADDR_W     = 25,
    localparam int QID_W     = $clog2(NUM_Q),
    localparam int CNT_W     = DEPTH_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ready,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [QID_W-1:0]  req_qid,
    input  logic [CNT_W-1:0]  afull_level,
    input  logic [CNT_W-1:0]  aempty_level,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rsp_valid,
    output logic [QID_W-1:0]  rsp_qid,
    output logic              rsp_err,
    output logic              rsp_empty,
    output logic              rsp_full,
    output logic              rsp_afull,
    output logic              rsp_aempty,
    output logic              svc_req,
    output logic [QID_W-1:0]  svc_qid
);
    import qm_pkg::*;

    localparam int PTR_W   = QID_W + CNT_W;
    localparam int DESC_W  = 4 + 2 * PTR_W;
    localparam int OFF_W   = FRAME_LOG2 + DEPTH_LOG2;
    localparam int EMPTY_B = 2 * PTR_W + 2;
    localparam logic [QID_W-1:0] LAST_Q = QID_W'(NUM_Q - 1);

    qm_state_e          state, state_nx;
    logic [QID_W-1:0]   load_cnt;
    logic               accept;

    logic               s1_valid, s1_write, s1_fwd;
    logic [QID_W-1:0]   s1_qid;
    logic [DESC_W-1:0]  fwd_desc, ram_rdata, cur_desc, wb_desc;
    logic               ram_we;
    logic [QID_W-1:0]   ram_waddr;
    logic [DESC_W-1:0]  ram_wdata;

    logic [PTR_W-1:0]   head, tail, new_head, new_tail, sel_ptr;
    logic [CNT_W-1:0]   pre_occ, post_occ;
    logic               pre_empty, pre_full, pre_afull, pre_aempty;
    logic               post_empty, post_full, post_afull, post_aempty;
    logic               do_mem;

    // ---------------- controller ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= QM_LOAD;
            load_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == QM_LOAD) load_cnt <= load_cnt + QID_W'(1);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            QM_LOAD:  if (load_cnt == LAST_Q) state_nx = QM_SERVE;
            QM_SERVE: state_nx = QM_SERVE;
        endcase
    end

    assign ready  = (state == QM_SERVE);
    assign accept = req_valid && ready;

    // ---------------- access pipeline ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_write <= 1'b0;
            s1_qid   <= '0;
            s1_fwd   <= 1'b0;
            fwd_desc <= '0;
        end else begin
            s1_valid <= accept;
            s1_write <= req_write;
            s1_qid   <= req_qid;
            s1_fwd   <= accept && s1_valid && (s1_qid == req_qid);
            fwd_desc <= wb_desc;
        end
    end

    qm_desc_ram #(.WORDS(NUM_Q), .W(DESC_W)) u_ram (
        .clk   (clk),
        .rd_en (accept),
        .raddr (req_qid),
        .rdata (ram_rdata),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata)
    );

    assign cur_desc = s1_fwd ? fwd_desc : ram_rdata;
    assign head     = cur_desc[2*PTR_W-1:PTR_W];
    assign tail     = cur_desc[PTR_W-1:0];

    qm_occ_flags #(.CNT_W(CNT_W)) u_pre (
        .head_cnt (head[CNT_W-1:0]), .tail_cnt (tail[CNT_W-1:0]),
        .afull_level (afull_level), .aempty_level (aempty_level),
        .occ (pre_occ), .empty (pre_empty), .full (pre_full),
        .afull (pre_afull), .aempty (pre_aempty)
    );

    always_comb begin
        do_mem   = s1_valid && (s1_write ? !pre_full : !pre_empty);
        new_head = head;
        new_tail = tail;
        if (do_mem && s1_write)
            new_tail = {tail[PTR_W-1:CNT_W], tail[CNT_W-1:0] + CNT_W'(1)};
        if (do_mem && !s1_write)
            new_head = {head[PTR_W-1:CNT_W], head[CNT_W-1:0] + CNT_W'(1)};
        sel_ptr  = s1_write ? tail : head;
    end

    qm_occ_flags #(.CNT_W(CNT_W)) u_post (
        .head_cnt (new_head[CNT_W-1:0]), .tail_cnt (new_tail[CNT_W-1:0]),
        .afull_level (afull_level), .aempty_level (aempty_level),
        .occ (post_occ), .empty (post_empty), .full (post_full),
        .afull (post_afull), .aempty (post_aempty)
    );

    assign wb_desc = {post_full, post_empty, post_afull, post_aempty, new_head, new_tail};

    // descriptor write port: base loading, then write-back
    always_comb begin
        if (state == QM_LOAD) begin
            ram_we    = 1'b1;
            ram_waddr = load_cnt;
            ram_wdata = {4'b0101, load_cnt, CNT_W'(0), load_cnt, CNT_W'(0)};
        end else begin
            ram_we    = s1_valid;
            ram_waddr = s1_qid;
            ram_wdata = wb_desc;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_valid  = do_mem;
        mem_write  = s1_write;
        mem_addr   = ADDR_W'({sel_ptr[PTR_W-1:CNT_W], sel_ptr[DEPTH_LOG2-1:0],
                              FRAME_LOG2'(0)});
        rsp_valid  = s1_valid;
        rsp_qid    = s1_qid;
        rsp_err    = s1_valid && s1_write && pre_full;
        rsp_empty  = post_empty;
        rsp_full   = post_full;
        rsp_afull  = post_afull;
        rsp_aempty = post_aempty;
        svc_req    = do_mem && s1_write && post_full;
        svc_qid    = s1_qid;
    end

    // ---------------- assertions ----------------
    p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    p_quiet_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!mem_valid && !rsp_valid));
    p_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFF_W +: QID_W] == rsp_qid));
    p_err_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !mem_valid);
    p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_full && rsp_empty));
    p_stored_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_fwd) |-> (ram_rdata[EMPTY_B] == pre_empty));
    p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (post_occ <= (CNT_W'(1) << DEPTH_LOG2)));
    p_svc_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (rsp_full && mem_valid && mem_write));
endmodule

// File: tb/sim_qm_queue_mgr.sv
`timescale 1ns/1ps
module sim_qm_queue_mgr;
    localparam int NUM_Q = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_qid = '0;
    logic [7:0]  afull_level = 8'd126, aempty_level = 8'd1;
    logic        mem_valid, mem_write;
    logic [24:0] mem_addr;
    logic        rsp_valid, rsp_err, rsp_empty, rsp_full, rsp_afull, rsp_aempty;
    logic [5:0]  rsp_qid, svc_qid;
    logic        svc_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    qm_queue_mgr u0 (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .req_valid(req_valid), .req_write(req_write), .req_qid(req_qid),
        .afull_level(afull_level), .aempty_level(aempty_level),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .rsp_valid(rsp_valid), .rsp_qid(rsp_qid), .rsp_err(rsp_err),
        .rsp_empty(rsp_empty), .rsp_full(rsp_full), .rsp_afull(rsp_afull),
        .rsp_aempty(rsp_aempty), .svc_req(svc_req), .svc_qid(svc_qid)
    );

    typedef struct packed {
        logic       wr;
        logic [5:0] q;
        logic       mv;
        logic [6:0] idx;
        logic       emp;
        logic       full;
        logic       ae;
    } vec_t;

    // back-to-back requests; response checked one cycle later
    localparam vec_t VT [0:9] = '{
        '{1'b0, 6'd5,  1'b0, 7'd0, 1'b1, 1'b0, 1'b1},  // R5 empty read
        '{1'b1, 6'd5,  1'b1, 7'd0, 1'b0, 1'b0, 1'b1},  // R2
        '{1'b1, 6'd5,  1'b1, 7'd1, 1'b0, 1'b0, 1'b0},  // R10 same queue
        '{1'b1, 6'd9,  1'b1, 7'd0, 1'b0, 1'b0, 1'b1},  // R11
        '{1'b0, 6'd5,  1'b1, 7'd0, 1'b0, 1'b0, 1'b1},  // R3
        '{1'b0, 6'd5,  1'b1, 7'd1, 1'b1, 1'b0, 1'b1},  // R10 R7
        '{1'b0, 6'd5,  1'b0, 7'd0, 1'b1, 1'b0, 1'b1},  // R5
        '{1'b1, 6'd5,  1'b1, 7'd2, 1'b0, 1'b0, 1'b1},  // R5 pointers kept
        '{1'b0, 6'd9,  1'b1, 7'd0, 1'b1, 1'b0, 1'b1},  // R11
        '{1'b1, 6'd63, 1'b1, 7'd0, 1'b0, 1'b0, 1'b1}   // R2 last queue
    };

    function automatic logic [24:0] addr_of(input int q, input int idx);
        return 25'((q << 13) | (idx << 6));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [5:0] q);
        req_valid = 1'b1;
        req_write = wr;
        req_qid   = q;
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        logic seen;
        // ---- R1 reset and load ----
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", 32'(ready), 0);
        chk("R1 no mem access in reset", 32'(mem_valid), 0);
        rst_n     = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_qid = 6'd20;
        n = 0; seen = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (!ready && (rsp_valid || mem_valid)) seen = 1'b1;
        end while (!ready && n < 1000);
        req_valid = 1'b0;
        chk("R1 load cycles", 32'(n), NUM_Q);
        chk("R1 requests ignored while loading", 32'(seen), 0);
        @(negedge clk);
        chk("R1 ready stays high", 32'(ready), 1);
        issue(1'b0, 6'd20);
        chk("R1 ignored write left queue empty", 32'(rsp_empty), 1);
        chk("R1 ignored write no read", 32'(mem_valid), 0);
        idle();

        // ---- table walk ----
        for (int i = 0; i < 10; i++) begin
            issue(VT[i].wr, VT[i].q);
            chk("R10/R11 rsp_valid", 32'(rsp_valid), 1);
            chk("R5 mem_valid", 32'(mem_valid), 32'(VT[i].mv));
            if (VT[i].mv) begin
                chk("R2/R3 mem_write", 32'(mem_write), 32'(VT[i].wr));
                chk("R2/R3 mem_addr", 32'(mem_addr), 32'(addr_of(VT[i].q, VT[i].idx)));
            end
            chk("R7 empty", 32'(rsp_empty), 32'(VT[i].emp));
            chk("R7 full", 32'(rsp_full), 32'(VT[i].full));
            chk("R8 aempty", 32'(rsp_aempty), 32'(VT[i].ae));
        end
        idle();

        // ---- fill queue 3: R4 R7 R8 R9 ----
        for (int i = 0; i < 128; i++) begin
            issue(1'b1, 6'd3);
            chk("R2 fill addr", 32'(mem_addr), 32'(addr_of(3, i)));
            if (i == 124) chk("R8 afull below level", 32'(rsp_afull), 0);
            if (i == 125) chk("R8 afull at level", 32'(rsp_afull), 1);
            if (i == 126) chk("R9 no early svc", 32'(svc_req), 0);
            if (i == 127) begin
                chk("R7 full", 32'(rsp_full), 1);
                chk("R9 svc_req", 32'(svc_req), 1);
                chk("R9 svc_qid", 32'(svc_qid), 3);
            end
        end
        issue(1'b1, 6'd3);
        chk("R6 rsp_err", 32'(rsp_err), 1);
        chk("R6 no mem write", 32'(mem_valid), 0);
        chk("R9 no svc on refusal", 32'(svc_req), 0);
        issue(1'b0, 6'd3);
        chk("R3 head addr", 32'(mem_addr), 32'(addr_of(3, 0)));
        chk("R7 not full", 32'(rsp_full), 0);
        issue(1'b1, 6'd3);
        chk("R4 tail wraps to base", 32'(mem_addr), 32'(addr_of(3, 0)));
        chk("R9 svc again", 32'(svc_req), 1);
        issue(1'b0, 6'd3);
        chk("R6 head unchanged by refusal", 32'(mem_addr), 32'(addr_of(3, 1)));
        idle();
        issue(1'b0, 6'd9);
        chk("R11 other queue still empty", 32'(mem_valid), 0);
        idle();
        finish_run();
    end
endmodule